// File: doc/BRIEF.md
# Raster Timing and Color Bar Generator

This block produces the complete non-interlaced raster timing for a 60 Hz or 50 Hz picture from a single pixel clock. A dot counter and a line counter drive registered horizontal sync, composite sync, blanking and a vertical-retrace status flag. The frame length is picked by a standard input and a line-count select input.

From the counters it marks the image window and the smaller graphics window inside it. Each window can be shifted by signed fine-position offsets. The ring between the two windows is reported as border. Inside the graphics window the block reports pixel coordinates, which a downstream drawing engine uses to fetch video.

When color bar mode is on, the block emits a 12-bit RGB test pattern of eight equal vertical bars in the graphics window and black everywhere else. All outputs are registered and describe the counter state of the previous clock. Changes to any control input therefore show up one clock later.

Top module: `raster_timing_gen`

## Requirements
- R1: While `rst` is high, every output is in its idle state: `hsync_n`=1, `csync_n`=1, `blank`=1, `vblank`=1, `border`=0, `active`=0, `px`=0, `py`=0, `rgb`=0.
- R2: Each line is DOTS clocks long. `hsync_n` is low for dots 0 to HS_W-1 of every line and high on all other dots.
- R3: The frame length in lines is 263 when `std50`=0 and `line_sel`=0, and 262 when `std50`=0 and `line_sel`=1. It is 312 when `std50`=1 and `line_sel`=1, and 314 when `std50`=1 and `line_sel`=0.
- R4: `vblank` is high on lines 0 to 18 when `std50`=0 and on lines 0 to 24 when `std50`=1. `blank` is high whenever `vblank` is high, and also on every dot outside the window VIS_START to VIS_START+VIS_W-1.
- R5: When `vsync_only`=0 and `eq_en`=1, lines 0–2 and 6–8 carry equalizing pulses on `csync_n`: low for dots below HS_W/2, and low for dots DOTS/2 to DOTS/2+HS_W/2-1. Lines 3–5 carry broad pulses: low for dots below DOTS/2-HS_W, and low for dots DOTS/2 to DOTS-HS_W-1. On all other lines `csync_n` equals `hsync_n`.
- R6: When `vsync_only`=0 and `eq_en`=0, the broad pulses of lines 3–5 are kept and lines 0–2 and 6–8 follow `hsync_n`. When `vsync_only`=1, `csync_n` is low on every dot of lines 3–5 and high everywhere else; this setting takes priority over `eq_en`.
- R7: `hofs` and `vofs` are 4-bit two's complement values in units of 2 dots (2 lines). The image window starts at dot H_IMG_BASE-2*hofs and at line V_IMG_BASE-2*vofs, so positive values move the picture left and up. The window is IMG_W dots by IMG_H lines.
- R8: The graphics window is GFX_W by GFX_H, inset (IMG_W-GFX_W)/2 dots and (IMG_H-GFX_H)/2 lines into the image window. `active` marks the graphics window, and `border` marks the image window minus the graphics window. Both are low wherever `blank` would be high.
- R9: While `active` is high, `px` and `py` give the dot and line offset from the graphics window's top-left corner. Otherwise both are 0.
- R10: With `cb_en`=1, `rgb` (packed as R in bits 11:8, G in 7:4, B in 3:0) inside the graphics window shows bar index `px`/(GFX_W/8). The bars in index order 0..7 are FFF, BBB, FF0, 0FF, 0F0, F0F, F00, 00F (white, gray, yellow, cyan, green, magenta, red, blue).
- R11: `rgb` is 000 (black) on the border and everywhere outside the graphics window, and is 000 on every dot when `cb_en`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| std50 | input | 1 | 0: 60 Hz raster, 1: 50 Hz raster |
| line_sel | input | 1 | Frame-length select (see R3) |
| hofs | input | 4 | Horizontal offset, two's complement, 2-dot units, positive = left |
| vofs | input | 4 | Vertical offset, two's complement, 2-line units, positive = up |
| eq_en | input | 1 | Include equalizing pulses in composite sync |
| vsync_only | input | 1 | Replace composite sync with a pure vertical sync |
| cb_en | input | 1 | Color bar pattern enable |
| hsync_n | output | 1 | Horizontal sync, active low |
| csync_n | output | 1 | Composite or vertical sync, active low |
| blank | output | 1 | Blanking, active high |
| vblank | output | 1 | Vertical-retrace status flag |
| border | output | 1 | Dot is in the border ring |
| active | output | 1 | Dot is in the graphics window |
| px | output | PXW | Graphics-window dot coordinate |
| py | output | PYW | Graphics-window line coordinate |
| rgb | output | 12 | Color bar value {R,G,B} |

## Verification
The vertical-retrace flag and the area flags can fall in the same cycle: a large positive vertical offset places the top of the image window inside retrace, and the area flags must stay low until retrace ends and then start mid-image. The bench provokes this with `vofs`=+7 on a 50 Hz and a 60 Hz frame, and with `vofs`=-8 at the other extreme. A reference model built from the requirement arithmetic judges every output on every dot, so the cycle where `vblank` falls and `border` or `active` rises is compared exactly. Frame lengths are judged separately, by timing the rising edges of `vblank` against 263, 262, 312 and 314 lines.

// File: rtl/rtg_pkg.sv
package rtg_pkg;

    localparam int V_W       = 9;   // enough for 314 lines
    localparam int VS_FIRST  = 3;   // first broad-pulse line
    localparam int VS_LAST   = 5;   // last broad-pulse line
    localparam int EQ_LAST   = 8;   // last equalizing line

    typedef struct packed {
        logic [3:0] r;
        logic [3:0] g;
        logic [3:0] b;
    } rgb12_t;

    function automatic int frame_lines(input logic std50, input logic line_sel);
        if (std50) return line_sel ? 312 : 314;
        return line_sel ? 262 : 263;
    endfunction

    function automatic int retrace_lines(input logic std50);
        return std50 ? 25 : 19;
    endfunction

    function automatic rgb12_t bar_color(input logic [2:0] idx);
        rgb12_t c;
        case (idx)
            3'd0:    c = '{r: 4'hF, g: 4'hF, b: 4'hF};
            3'd1:    c = '{r: 4'hB, g: 4'hB, b: 4'hB};
            3'd2:    c = '{r: 4'hF, g: 4'hF, b: 4'h0};
            3'd3:    c = '{r: 4'h0, g: 4'hF, b: 4'hF};
            3'd4:    c = '{r: 4'h0, g: 4'hF, b: 4'h0};
            3'd5:    c = '{r: 4'hF, g: 4'h0, b: 4'hF};
            3'd6:    c = '{r: 4'hF, g: 4'h0, b: 4'h0};
            default: c = '{r: 4'h0, g: 4'h0, b: 4'hF};
        endcase
        return c;
    endfunction

endpackage

// File: rtl/rtg_counter.sv
module rtg_counter
    import rtg_pkg::*;
#(
    parameter int DOTS = 456,
    localparam int HW  = $clog2(DOTS)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [V_W-1:0] last_line,
    output logic [HW-1:0]  h,
    output logic [V_W-1:0] v
);
    always_ff @(posedge clk) begin
        if (rst) begin
            h <= '0;
            v <= '0;
        end else if (int'(h) == DOTS - 1) begin
            h <= '0;
            v <= (v >= last_line) ? '0 : v + 1'b1;
        end else begin
            h <= h + 1'b1;
        end
    end
endmodule

// File: rtl/rtg_sync.sv
module rtg_sync
    import rtg_pkg::*;
#(
    parameter int DOTS      = 456,
    parameter int HS_W      = 34,
    parameter int VIS_START = 80,
    parameter int VIS_W     = 360,
    localparam int HW       = $clog2(DOTS),
    localparam int HALF     = DOTS / 2,
    localparam int EQ_W     = HS_W / 2
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [HW-1:0]  h,
    input  logic [V_W-1:0] v,
    input  logic           std50,
    input  logic           eq_en,
    input  logic           vsync_only,
    output logic           vis_c,
    output logic           hsync_n,
    output logic           csync_n,
    output logic           blank,
    output logic           vblank
);
    int   hs, vs;
    logic retr_c, hs_low, broad_low, eq_low, cs_low, vs_band, eq_band;

    always_comb begin
        hs        = int'(h);
        vs        = int'(v);
        retr_c    = vs < retrace_lines(std50);
        vis_c     = !retr_c && hs >= VIS_START && hs < VIS_START + VIS_W;
        hs_low    = hs < HS_W;
        broad_low = (hs < HALF - HS_W) || (hs >= HALF && hs < DOTS - HS_W);
        eq_low    = (hs < EQ_W) || (hs >= HALF && hs < HALF + EQ_W);
        vs_band   = vs >= VS_FIRST && vs <= VS_LAST;
        eq_band   = vs <= EQ_LAST && !vs_band;
        if (vsync_only)            cs_low = vs_band;
        else if (vs_band)          cs_low = broad_low;
        else if (eq_en && eq_band) cs_low = eq_low;
        else                       cs_low = hs_low;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hsync_n <= 1'b1;
            csync_n <= 1'b1;
            blank   <= 1'b1;
            vblank  <= 1'b1;
        end else begin
            hsync_n <= !hs_low;
            csync_n <= !cs_low;
            blank   <= !vis_c;
            vblank  <= retr_c;
        end
    end
endmodule

// File: rtl/rtg_area.sv
module rtg_area
    import rtg_pkg::*;
#(
    parameter int DOTS       = 456,
    parameter int IMG_W      = 300,
    parameter int IMG_H      = 216,
    parameter int GFX_W      = 288,
    parameter int GFX_H      = 192,
    parameter int H_IMG_BASE = 110,
    parameter int V_IMG_BASE = 30,
    localparam int HW        = $clog2(DOTS),
    localparam int PXW       = $clog2(GFX_W),
    localparam int PYW       = $clog2(GFX_H),
    localparam int H_INSET   = (IMG_W - GFX_W) / 2,
    localparam int V_INSET   = (IMG_H - GFX_H) / 2,
    localparam int BAR_W     = GFX_W / 8
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [HW-1:0]  h,
    input  logic [V_W-1:0] v,
    input  logic           vis_c,
    input  logic [3:0]     hofs,
    input  logic [3:0]     vofs,
    input  logic           cb_en,
    output logic           border,
    output logic           active,
    output logic [PXW-1:0] px,
    output logic [PYW-1:0] py,
    output rgb12_t         rgb
);
    int     hs, vs, x0, y0, gx0, gy0, pxi, pyi;
    logic   in_img, in_gfx, act_c, bord_c;
    rgb12_t col_c;

    always_comb begin
        hs     = int'(h);
        vs     = int'(v);
        x0     = H_IMG_BASE - 2 * int'($signed(hofs));
        y0     = V_IMG_BASE - 2 * int'($signed(vofs));
        gx0    = x0 + H_INSET;
        gy0    = y0 + V_INSET;
        in_img = hs >= x0 && hs < x0 + IMG_W && vs >= y0 && vs < y0 + IMG_H;
        in_gfx = hs >= gx0 && hs < gx0 + GFX_W && vs >= gy0 && vs < gy0 + GFX_H;
        act_c  = in_gfx && vis_c;
        bord_c = in_img && !in_gfx && vis_c;
        pxi    = act_c ? hs - gx0 : 0;
        pyi    = act_c ? vs - gy0 : 0;
        col_c  = (cb_en && act_c) ? bar_color(3'(pxi / BAR_W)) : '0;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            border <= 1'b0;
            active <= 1'b0;
            px     <= '0;
            py     <= '0;
            rgb    <= '0;
        end else begin
            border <= bord_c;
            active <= act_c;
            px     <= PXW'(pxi);
            py     <= PYW'(pyi);
            rgb    <= col_c;
        end
    end
endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
    import rtg_pkg::*;
#(
    parameter int DOTS       = 456,
    parameter int HS_W       = 34,
    parameter int VIS_START  = 80,
    parameter int VIS_W      = 360,
    parameter int IMG_W      = 300,
    parameter int IMG_H      = 216,
    parameter int GFX_W      = 288,
    parameter int GFX_H      = 192,
    parameter int H_IMG_BASE = 110,
    parameter int V_IMG_BASE = 30,
    localparam int HW        = $clog2(DOTS),
    localparam int PXW       = $clog2(GFX_W),
    localparam int PYW       = $clog2(GFX_H)
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           std50,
    input  logic           line_sel,
    input  logic [3:0]     hofs,
    input  logic [3:0]     vofs,
    input  logic           eq_en,
    input  logic           vsync_only,
    input  logic           cb_en,
    output logic           hsync_n,
    output logic           csync_n,
    output logic           blank,
    output logic           vblank,
    output logic           border,
    output logic           active,
    output logic [PXW-1:0] px,
    output logic [PYW-1:0] py,
    output logic [11:0]    rgb
);
    logic [HW-1:0]  h;
    logic [V_W-1:0] v;
    logic [V_W-1:0] last_line;
    logic           vis_c;
    rgb12_t         rgb_s;

    assign last_line = V_W'(frame_lines(std50, line_sel) - 1);
    assign rgb       = rgb_s;

    rtg_counter #(.DOTS(DOTS)) u_cnt (
        .clk(clk), .rst(rst), .last_line(last_line), .h(h), .v(v)
    );

    rtg_sync #(
        .DOTS(DOTS), .HS_W(HS_W), .VIS_START(VIS_START), .VIS_W(VIS_W)
    ) u_sync (
        .clk(clk), .rst(rst), .h(h), .v(v), .std50(std50), .eq_en(eq_en),
        .vsync_only(vsync_only), .vis_c(vis_c), .hsync_n(hsync_n),
        .csync_n(csync_n), .blank(blank), .vblank(vblank)
    );

    rtg_area #(
        .DOTS(DOTS), .IMG_W(IMG_W), .IMG_H(IMG_H), .GFX_W(GFX_W),
        .GFX_H(GFX_H), .H_IMG_BASE(H_IMG_BASE), .V_IMG_BASE(V_IMG_BASE)
    ) u_area (
        .clk(clk), .rst(rst), .h(h), .v(v), .vis_c(vis_c), .hofs(hofs),
        .vofs(vofs), .cb_en(cb_en), .border(border), .active(active),
        .px(px), .py(py), .rgb(rgb_s)
    );
endmodule

// File: rtl/rtg_checker.sv
module rtg_checker #(
    parameter int PXW = 9,
    parameter int PYW = 8
) (
    input logic           clk,
    input logic           rst,
    input logic           cb_en,
    input logic           hsync_n,
    input logic           blank,
    input logic           vblank,
    input logic           border,
    input logic           active,
    input logic [PXW-1:0] px,
    input logic [PYW-1:0] py,
    input logic [11:0]    rgb
);
    // R2: a sync pulse lasts more than one dot
    a_r2_hsync_width: assert property (@(posedge clk) disable iff (rst)
        $fell(hsync_n) |=> !hsync_n);

    // R4: retrace implies blanking
    a_r4_vblank_blanks: assert property (@(posedge clk) disable iff (rst)
        vblank |-> blank);

    // R8: border and graphics window never overlap
    a_r8_areas_disjoint: assert property (@(posedge clk) disable iff (rst)
        !(border && active));

    // R8: area flags stay low while blanked
    a_r8_area_unblanked: assert property (@(posedge clk) disable iff (rst)
        (border || active) |-> !blank);

    // R9: coordinates are zero outside the graphics window
    a_r9_coords_idle: assert property (@(posedge clk) disable iff (rst)
        !active |-> (px == '0 && py == '0));

    // R10: colored output only inside the graphics window
    a_r10_color_in_window: assert property (@(posedge clk) disable iff (rst)
        (rgb != 12'h000) |-> active);

    // R11: disabled pattern yields black on the next dot
    a_r11_disabled_black: assert property (@(posedge clk) disable iff (rst)
        !$past(cb_en) |-> (rgb == 12'h000));
endmodule

bind raster_timing_gen rtg_checker #(.PXW(PXW), .PYW(PYW)) u_chk (
    .clk(clk), .rst(rst), .cb_en(cb_en), .hsync_n(hsync_n), .blank(blank),
    .vblank(vblank), .border(border), .active(active), .px(px), .py(py),
    .rgb(rgb)
);

// File: tb/raster_timing_gen_test.sv
module raster_timing_gen_test;
    localparam int DOTS  = 96;
    localparam int HS_W  = 6;
    localparam int VIS_S = 8;
    localparam int VIS_W = 80;
    localparam int IMG_W = 40;
    localparam int IMG_H = 216;
    localparam int GFX_W = 32;
    localparam int GFX_H = 192;
    localparam int HB    = 24;
    localparam int VB    = 30;
    localparam int PXW   = $clog2(GFX_W);
    localparam int PYW   = $clog2(GFX_H);

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic std50, line_sel, eq_en, vsync_only, cb_en;
    logic [3:0] hofs, vofs;
    logic hsync_n, csync_n, blank, vblank, border, active;
    logic [PXW-1:0] px;
    logic [PYW-1:0] py;
    logic [11:0] rgb;

    always #10 clk = ~clk;

    raster_timing_gen #(
        .DOTS(DOTS), .HS_W(HS_W), .VIS_START(VIS_S), .VIS_W(VIS_W),
        .IMG_W(IMG_W), .IMG_H(IMG_H), .GFX_W(GFX_W), .GFX_H(GFX_H),
        .H_IMG_BASE(HB), .V_IMG_BASE(VB)
    ) uut (.*);

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    int len_exp [0:5];

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // frame configurations: {std50, line_sel, hofs, vofs, eq, vso, cb}
    task automatic apply_cfg(input int f);
        case (f % 5)
            0: begin std50=0; line_sel=1; hofs=4'd0;  vofs=4'd0;  eq_en=1; vsync_only=0; cb_en=0; end
            1: begin std50=0; line_sel=0; hofs=4'd7;  vofs=4'h8;  eq_en=1; vsync_only=0; cb_en=1; end
            2: begin std50=0; line_sel=1; hofs=4'h8;  vofs=4'd7;  eq_en=0; vsync_only=0; cb_en=1; end
            3: begin std50=1; line_sel=1; hofs=4'd3;  vofs=4'hF; eq_en=1; vsync_only=1; cb_en=1; end
            default: begin std50=1; line_sel=0; hofs=4'hF; vofs=4'd7; eq_en=1; vsync_only=0; cb_en=0; end
        endcase
        if (f <= 5)
            len_exp[f] = DOTS * (std50 ? (line_sel ? 312 : 314) : (line_sel ? 262 : 263));
    endtask

    function automatic int sx4(input logic [3:0] x);
        return (x >= 8) ? int'(x) - 16 : int'(x);
    endfunction

    function automatic logic [11:0] bar(input int i);
        case (i)
            0: return 12'hFFF; 1: return 12'hBBB; 2: return 12'hFF0; 3: return 12'h0FF;
            4: return 12'h0F0; 5: return 12'hF0F; 6: return 12'hF00; default: return 12'h00F;
        endcase
    endfunction

    // expected outputs
    logic e_hs, e_cs, e_bl, e_vb, e_bo, e_ac;
    int   e_px, e_py;
    logic [11:0] e_rgb;

    task automatic model(input int h, input int v);
        int vr, x0, y0, gx, gy;
        bit vis, inimg, ingfx, hlow, vsb;
        vr    = std50 ? 25 : 19;
        vis   = (v >= vr) && h >= VIS_S && h < VIS_S + VIS_W;
        hlow  = h < HS_W;
        vsb   = v >= 3 && v <= 5;
        e_hs  = !hlow;
        if (vsync_only)  e_cs = !vsb;
        else if (vsb)    e_cs = !((h < DOTS/2 - HS_W) || (h >= DOTS/2 && h < DOTS - HS_W));
        else if (eq_en && v <= 8)
                         e_cs = !((h < HS_W/2) || (h >= DOTS/2 && h < DOTS/2 + HS_W/2));
        else             e_cs = !hlow;
        e_bl  = !vis;
        e_vb  = v < vr;
        x0    = HB - 2 * sx4(hofs);
        y0    = VB - 2 * sx4(vofs);
        gx    = x0 + (IMG_W - GFX_W) / 2;
        gy    = y0 + (IMG_H - GFX_H) / 2;
        inimg = h >= x0 && h < x0 + IMG_W && v >= y0 && v < y0 + IMG_H;
        ingfx = h >= gx && h < gx + GFX_W && v >= gy && v < gy + GFX_H;
        e_ac  = vis && ingfx;
        e_bo  = vis && inimg && !ingfx;
        e_px  = e_ac ? h - gx : 0;
        e_py  = e_ac ? v - gy : 0;
        e_rgb = (cb_en && e_ac) ? bar(e_px / (GFX_W / 8)) : 12'h000;
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin : main
        int mh, mv, frame, cyc, rises, last_rise;
        bit have, pvb, csreq;
        apply_cfg(0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R1 reset state
        chk(hsync_n == 1, "R1", "hsync_n", hsync_n, 1);
        chk(csync_n == 1, "R1", "csync_n", csync_n, 1);
        chk(blank   == 1, "R1", "blank",   blank,   1);
        chk(vblank  == 1, "R1", "vblank",  vblank,  1);
        chk(border  == 0, "R1", "border",  border,  0);
        chk(active  == 0, "R1", "active",  active,  0);
        chk(px == 0,      "R1", "px", px, 0);
        chk(py == 0,      "R1", "py", py, 0);
        chk(rgb == 0,     "R1", "rgb", rgb, 0);
        rst = 0;
        mh = 0; mv = 0; frame = 0; cyc = 0; rises = 0; last_rise = 0;
        have = 0; pvb = 1; csreq = 0;
        forever begin
            if (have) begin
                chk(hsync_n == e_hs, "R2", "hsync_n", hsync_n, e_hs);
                chk(csync_n == e_cs, csreq ? "R5" : "R6", "csync_n", csync_n, e_cs);
                chk(blank == e_bl,   "R4", "blank", blank, e_bl);
                chk(vblank == e_vb,  "R4", "vblank", vblank, e_vb);
                chk(border == e_bo,  "R8", "border", border, e_bo);
                chk(active == e_ac,  "R7", "active", active, e_ac);
                chk(int'(px) == e_px, "R9", "px", px, e_px);
                chk(int'(py) == e_py, "R9", "py", py, e_py);
                chk(rgb == e_rgb, cb_en ? "R10" : "R11", "rgb", rgb, e_rgb);
                if (vblank && !pvb) begin
                    rises++;
                    if (rises >= 2)
                        chk(cyc - last_rise == len_exp[rises - 1], "R3", "frame length",
                            cyc - last_rise, len_exp[rises - 1]);
                    last_rise = cyc;
                end
                pvb = vblank;
            end
            if (frame == 5 && mh == 4) break;
            if (mh == 0 && mv == 0 && frame > 0) apply_cfg(frame);
            csreq = eq_en && !vsync_only;
            model(mh, mv);
            have = 1;
            if (mh == DOTS - 1) begin
                mh = 0;
                if (mv >= (std50 ? (line_sel ? 312 : 314) : (line_sel ? 262 : 263)) - 1) begin
                    mv = 0;
                    frame++;
                end else mv++;
            end else mh++;
            @(negedge clk);
            cyc++;
        end
        chk(rises == 5, "R3", "frame starts seen", rises, 5);
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule